// File: doc/BRIEF.md
# Flash Operating-Mode and Reset Controller

This block is a synthesizable behavioural model of the mode sequencer in a parallel NOR flash device. It keeps track of which operating mode the device is in:

- plain array read
- a half-entered command sequence
- identifier query and parameter query
- the sector-erase collection window
- active programming or erasing
- erase suspend and a program issued while erase is suspended
- the two failure modes
- recovery after a hardware reset

It takes already-decoded command strobes, an active-low hardware reset pin and completion or failure pulses from an abstract array engine. From these it produces the current mode code, a ready/busy level and the DQ5 failure flag.

Two reset paths are modelled. The hardware pin always wins, but only when it has been held low long enough. When it arrives during an active array operation, the return to read waits out a bounded recovery time. The software reset command clears the query, failure and partial-sequence modes. It has no effect while an operation is actually running.

The pin is resynchronised, filtered for a minimum width and counted in system clocks. All timing windows are parameters.

Top module: `flash_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs are `mode_o`=Read, `ready_o`=1 and `dq5_o`=0.
  - Mode codes: 0 Read, 1 Partial, 2 IdQuery, 3 ParamQuery, 4 EraseWindow, 5 Program, 6 Erase, 7 ProgFail, 8 EraseFail, 9 EraseSuspend, 10 SuspPartial, 11 SuspProgram, 12 HwRecover.
  - Command codes on `cmd_i`: 0 Reset, 1 Unlock, 2 IdQuery, 3 ParamQuery, 4 Program, 5 EraseSetup, 6 Suspend, 7 Resume.
- R2: After the synchronised pin has been low for `RST_MIN_CYC` consecutive cycles, a mode outside Program/Erase/SuspProgram/HwRecover becomes Read on the next edge.
- R3: A pin low pulse shorter than `RST_MIN_CYC` cycles leaves the mode unchanged.
- R4: An accepted pin reset in Program, Erase or SuspProgram enters HwRecover. HwRecover lasts exactly `RECOVER_CYC` cycles and then becomes Read.
- R5: The Reset command returns Partial, SuspPartial and EraseWindow to Read on the next edge.
- R6: IdQuery and ParamQuery are entered from Read or Partial. They are left only by the Reset command or a pin reset. Other commands and engine pulses have no effect in these modes.
- R7: In Program, SuspProgram and Erase, every command except Suspend (in Erase only) is ignored. Only engine pulses end these modes.
- R8: An engine fail pulse turns Program or SuspProgram into ProgFail and Erase into EraseFail. Fail wins over a simultaneous done pulse. A failure mode holds until the Reset command.
- R9: `dq5_o` is 1 exactly in ProgFail and EraseFail, and it returns to 0 when Read is re-entered.
- R10: `ready_o` is 0 exactly in EraseWindow, Program, Erase, SuspProgram and HwRecover.
- R11: Program from Read or Partial enters Program, and done returns it to Read. EraseSetup enters EraseWindow, which lasts `ERASE_WIN_CYC` cycles before Erase; a further EraseSetup restarts the window. Done in Erase returns to Read.
- R12: Suspend turns Erase into EraseSuspend, which ignores Reset. Within EraseSuspend:
  - Unlock gives SuspPartial.
  - Program (from EraseSuspend or SuspPartial) gives SuspProgram, whose done pulse returns to EraseSuspend.
  - Resume returns to Erase.
- R13: Commands arriving while the synchronised pin is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| rst_pin_n | input | 1 | Device hardware reset pin, active low, asynchronous to clk |
| cmd_vld_i | input | 1 | Decoded command strobe, one cycle |
| cmd_i | input | 3 | Decoded command code (see R1) |
| eng_done_i | input | 1 | Array operation finished without error |
| eng_fail_i | input | 1 | Array operation failed |
| mode_o | output | 4 | Current operating mode code (see R1) |
| ready_o | output | 1 | Ready (1) / busy (0) |
| dq5_o | output | 1 | Failure status flag |

## Verification
Every mode is a registered code that drives `mode_o` directly, and `ready_o` and `dq5_o` are decoded from it. A wrong state transition therefore shows at the ports on the clock edge after the stimulus that caused it.

Timer faults need window measurements, because they only show as a length error. A wrong pulse-width filter, recovery counter or erase-window counter stretches or shortens the HwRecover or EraseWindow interval, or makes a short pin pulse act. The bench therefore measures these intervals cycle by cycle rather than sampling one point. A wrongly accepted or ignored software reset is visible one cycle after the strobe.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

   typedef enum logic [3:0] {
      M_READ     = 4'd0,
      M_PARTIAL  = 4'd1,
      M_IDQ      = 4'd2,
      M_PARQ     = 4'd3,
      M_ERSWIN   = 4'd4,
      M_PROG     = 4'd5,
      M_ERASE    = 4'd6,
      M_PFAIL    = 4'd7,
      M_EFAIL    = 4'd8,
      M_ESUSP    = 4'd9,
      M_SPART    = 4'd10,
      M_SPROG    = 4'd11,
      M_HWREC    = 4'd12
   } mode_e;

   typedef enum logic [2:0] {
      C_RESET   = 3'd0,
      C_UNLOCK  = 3'd1,
      C_IDQ     = 3'd2,
      C_PARQ    = 3'd3,
      C_PROG    = 3'd4,
      C_ESETUP  = 3'd5,
      C_SUSPEND = 3'd6,
      C_RESUME  = 3'd7
   } cmd_e;

   // Modes in which a pin reset must wait out the recovery interval.
   function automatic logic needs_recovery(mode_e m);
      return (m == M_PROG) || (m == M_ERASE) || (m == M_SPROG) || (m == M_HWREC);
   endfunction

   // Modes reported as busy on the ready/busy output.
   function automatic logic is_busy(mode_e m);
      return (m == M_ERSWIN) || (m == M_PROG) || (m == M_ERASE) ||
             (m == M_SPROG) || (m == M_HWREC);
   endfunction

   function automatic logic is_fail(mode_e m);
      return (m == M_PFAIL) || (m == M_EFAIL);
   endfunction

endpackage

// File: rtl/fmc_pin_filter.sv
// Resynchronises the hardware reset pin and raises a one-cycle accept pulse
// once it has stayed low for MIN_CYC consecutive cycles.
module fmc_pin_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_CYC     = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic pin_low,
   output logic fire
);
   localparam int              CW   = $clog2(MIN_CYC + 1);
   localparam logic [CW-1:0]   SAT  = CW'(MIN_CYC);
   localparam logic [CW-1:0]   LAST = CW'(MIN_CYC - 1);

   logic          pin_s;
   logic [CW-1:0] low_cnt;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign pin_s = pin_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr <= '1;
            end else begin
               sr[0] <= pin_n;
               for (int i = 1; i < SYNC_STAGES; i++) sr[i] <= sr[i-1];
            end
         end
         assign pin_s = sr[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            low_cnt <= '0;
      else if (pin_s)        low_cnt <= '0;
      else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
   end

   assign pin_low = !pin_s;
   assign fire    = !pin_s && (low_cnt == LAST);

endmodule

// File: rtl/fmc_down_timer.sv
// One-shot interval timer: done is high in the CYC-th cycle after start.
module fmc_down_timer #(
   parameter int CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done
);
   localparam int            CW   = (CYC > 1) ? $clog2(CYC) : 1;
   localparam logic [CW-1:0] LOAD = CW'(CYC - 1);

   logic          run;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         cnt <= '0;
      end else if (start) begin
         run <= 1'b1;
         cnt <= LOAD;
      end else if (done) begin
         run <= 1'b0;
      end else if (run) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign done = run && (cnt == '0);

endmodule

// File: rtl/fmc_mode_fsm.sv
module fmc_mode_fsm
   import fmc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  cmd_vld,
   input  cmd_e  cmd,
   input  logic  eng_done,
   input  logic  eng_fail,
   input  logic  pin_low,
   input  logic  hw_fire,
   input  logic  rec_done,
   input  logic  win_done,
   output mode_e mode,
   output logic  rec_start,
   output logic  win_start
);
   mode_e nxt;
   logic  cmd_ok;

   assign cmd_ok = cmd_vld && !pin_low;

   always_comb begin
      nxt       = mode;
      rec_start = 1'b0;
      win_start = 1'b0;
      if (hw_fire) begin
         if (needs_recovery(mode)) begin
            nxt       = M_HWREC;
            rec_start = 1'b1;
         end else begin
            nxt = M_READ;
         end
      end else begin
         unique case (mode)
            M_READ, M_PARTIAL: begin
               if (cmd_ok) begin
                  case (cmd)
                     C_RESET:  nxt = M_READ;
                     C_UNLOCK: nxt = M_PARTIAL;
                     C_IDQ:    nxt = M_IDQ;
                     C_PARQ:   nxt = M_PARQ;
                     C_PROG:   nxt = M_PROG;
                     C_ESETUP: begin
                        nxt       = M_ERSWIN;
                        win_start = 1'b1;
                     end
                     default:  nxt = mode;
                  endcase
               end
            end
            M_IDQ, M_PARQ, M_PFAIL, M_EFAIL: begin
               if (cmd_ok && cmd == C_RESET) nxt = M_READ;
            end
            M_ERSWIN: begin
               if (cmd_ok && cmd == C_RESET)       nxt = M_READ;
               else if (cmd_ok && cmd == C_ESETUP) win_start = 1'b1;
               else if (win_done)                  nxt = M_ERASE;
            end
            M_PROG: begin
               if (eng_fail)      nxt = M_PFAIL;
               else if (eng_done) nxt = M_READ;
            end
            M_ERASE: begin
               if (eng_fail)                        nxt = M_EFAIL;
               else if (eng_done)                   nxt = M_READ;
               else if (cmd_ok && cmd == C_SUSPEND) nxt = M_ESUSP;
            end
            M_ESUSP: begin
               if (cmd_ok) begin
                  case (cmd)
                     C_UNLOCK: nxt = M_SPART;
                     C_PROG:   nxt = M_SPROG;
                     C_RESUME: nxt = M_ERASE;
                     default:  nxt = mode;
                  endcase
               end
            end
            M_SPART: begin
               if (cmd_ok && cmd == C_RESET)     nxt = M_READ;
               else if (cmd_ok && cmd == C_PROG) nxt = M_SPROG;
            end
            M_SPROG: begin
               if (eng_fail)      nxt = M_PFAIL;
               else if (eng_done) nxt = M_ESUSP;
            end
            M_HWREC: begin
               if (rec_done) nxt = M_READ;
            end
            default: nxt = M_READ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode <= M_READ;
      else        mode <= nxt;
   end

endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
   import fmc_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int RST_MIN_CYC   = 16,
   parameter int RECOVER_CYC   = 64,
   parameter int ERASE_WIN_CYC = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rst_pin_n,
   input  logic       cmd_vld_i,
   input  logic [2:0] cmd_i,
   input  logic       eng_done_i,
   input  logic       eng_fail_i,
   output logic [3:0] mode_o,
   output logic       ready_o,
   output logic       dq5_o
);
   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..4");
      end
      if (RST_MIN_CYC < 1) begin : g_bad_min
         $error("RST_MIN_CYC must be at least 1");
      end
      if (RECOVER_CYC < 1) begin : g_bad_rec
         $error("RECOVER_CYC must be at least 1");
      end
      if (ERASE_WIN_CYC < 1) begin : g_bad_win
         $error("ERASE_WIN_CYC must be at least 1");
      end
   endgenerate

   logic  pin_low;
   logic  hw_fire;
   logic  rec_start, rec_done;
   logic  win_start, win_done;
   mode_e mode;

   fmc_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .MIN_CYC(RST_MIN_CYC)) u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_n   (rst_pin_n),
      .pin_low (pin_low),
      .fire    (hw_fire)
   );

   fmc_down_timer #(.CYC(RECOVER_CYC)) u_rec_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (rec_start),
      .done  (rec_done)
   );

   fmc_down_timer #(.CYC(ERASE_WIN_CYC)) u_win_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (win_start),
      .done  (win_done)
   );

   fmc_mode_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_vld   (cmd_vld_i),
      .cmd       (cmd_e'(cmd_i)),
      .eng_done  (eng_done_i),
      .eng_fail  (eng_fail_i),
      .pin_low   (pin_low),
      .hw_fire   (hw_fire),
      .rec_done  (rec_done),
      .win_done  (win_done),
      .mode      (mode),
      .rec_start (rec_start),
      .win_start (win_start)
   );

   assign mode_o  = mode;
   assign ready_o = !is_busy(mode);
   assign dq5_o   = is_fail(mode);

endmodule

// File: rtl/fmc_checker.sv
module fmc_checker
   import fmc_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       pin_low,
   input logic       hw_fire,
   input logic       cmd_vld,
   input logic [2:0] cmd,
   input logic       eng_done,
   input logic       eng_fail,
   input logic [3:0] mode,
   input logic       rdy,
   input logic       dq5
);
   logic sw_rst, in_query, in_fail, in_run, quiet_rst;

   assign sw_rst    = cmd_vld && !pin_low && (cmd == C_RESET);
   assign in_query  = (mode == M_IDQ) || (mode == M_PARQ);
   assign in_fail   = (mode == M_PFAIL) || (mode == M_EFAIL);
   assign in_run    = (mode == M_PROG) || (mode == M_SPROG) || (mode == M_ERASE);
   assign quiet_rst = (mode == M_PARTIAL) || (mode == M_SPART) || (mode == M_ERSWIN);

   // R1
   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |-> (mode == M_READ) && rdy && !dq5);

   a_r2_pin_rst_read: assert property (@(posedge clk) disable iff (!rst_n)
      hw_fire && !in_run && (mode != M_HWREC) |=> mode == M_READ);

   a_r4_pin_rst_recover: assert property (@(posedge clk) disable iff (!rst_n)
      hw_fire && in_run |=> mode == M_HWREC);

   a_r4_recover_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mode == M_HWREC |-> !rdy);

   a_r5_cmd_rst_read: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst && !hw_fire && quiet_rst |=> mode == M_READ);

   a_r6_query_hold: assert property (@(posedge clk) disable iff (!rst_n)
      in_query && !hw_fire && !sw_rst |=> $stable(mode));

   a_r7_run_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      in_run && !hw_fire && !eng_done && !eng_fail &&
      !(mode == M_ERASE && cmd_vld && !pin_low && cmd == C_SUSPEND) |=> $stable(mode));

   a_r8_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
      in_fail && !hw_fire && !sw_rst |=> $stable(mode));

   a_r9_dq5_from_fail: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq5) |-> $past(eng_fail));

   a_r9_read_dq5_low: assert property (@(posedge clk) disable iff (!rst_n)
      mode == M_READ |-> !dq5);

   a_r13_pin_low_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      pin_low && !hw_fire && !eng_done && !eng_fail && !in_run &&
      (mode != M_HWREC) && (mode != M_ERSWIN) |=> $stable(mode));

endmodule

bind flash_mode_ctrl fmc_checker u_fmc_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pin_low  (pin_low),
   .hw_fire  (hw_fire),
   .cmd_vld  (cmd_vld_i),
   .cmd      (cmd_i),
   .eng_done (eng_done_i),
   .eng_fail (eng_fail_i),
   .mode     (mode_o),
   .rdy      (ready_o),
   .dq5      (dq5_o)
);

// File: tb/flash_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_mode_ctrl_tb_top;
   localparam int MIN_W = 4;
   localparam int REC_W = 6;
   localparam int WIN_W = 5;

   localparam logic [2:0] K_RST = 3'd0, K_UNL = 3'd1, K_IDQ = 3'd2, K_PARQ = 3'd3,
                          K_PRG = 3'd4, K_ESU = 3'd5, K_SUS = 3'd6, K_RES = 3'd7;
   localparam logic [3:0] S_READ = 4'd0, S_PART = 4'd1, S_IDQ = 4'd2, S_PARQ = 4'd3,
                          S_EWIN = 4'd4, S_PROG = 4'd5, S_ERASE = 4'd6, S_PFAIL = 4'd7,
                          S_EFAIL = 4'd8, S_ESUSP = 4'd9, S_SPART = 4'd10,
                          S_SPROG = 4'd11, S_HWREC = 4'd12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_n = 1'b1;
   logic       cmd_vld = 1'b0;
   logic [2:0] cmd = 3'd0;
   logic       eng_done = 1'b0;
   logic       eng_fail = 1'b0;
   logic [3:0] mode;
   logic       rdy, dq5;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   flash_mode_ctrl #(
      .SYNC_STAGES(2), .RST_MIN_CYC(MIN_W), .RECOVER_CYC(REC_W), .ERASE_WIN_CYC(WIN_W)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .rst_pin_n(pin_n), .cmd_vld_i(cmd_vld), .cmd_i(cmd),
      .eng_done_i(eng_done), .eng_fail_i(eng_fail),
      .mode_o(mode), .ready_o(rdy), .dq5_o(dq5)
   );

   // vector: [15] strobe, [14:12] command, [11] done, [10] fail,
   //         [9:6] expected mode, [5] expected ready, [4] expected dq5, [3:0] requirement
   localparam int NV = 19;
   localparam logic [15:0] VEC [NV] = '{
      16'b1_001_0_0_0001_1_0_0101,   // R5 unlock -> partial
      16'b1_000_0_0_0000_1_0_0101,   // R5 reset clears partial
      16'b1_010_0_0_0010_1_0_0110,   // R6 id query
      16'b1_100_0_0_0010_1_0_0110,   // R6 program ignored in query
      16'b0_000_1_0_0010_1_0_0110,   // R6 engine pulse ignored
      16'b1_000_0_0_0000_1_0_0110,   // R6 reset leaves query
      16'b1_011_0_0_0011_1_0_0110,   // R6 parameter query
      16'b1_000_0_0_0000_1_0_0110,   // R6 reset leaves query
      16'b1_100_0_0_0101_0_0_1010,   // R10 program is busy
      16'b1_000_0_0_0101_0_0_0111,   // R7 reset ignored while programming
      16'b0_000_1_0_0000_1_0_1011,   // R11 done returns to read
      16'b1_001_0_0_0001_1_0_0101,   // R5 partial again
      16'b1_100_0_0_0101_0_0_1011,   // R11 program from partial
      16'b0_000_1_1_0111_1_1_1000,   // R8 fail wins over done
      16'b1_100_0_0_0111_1_1_1000,   // R8 fail holds against other command
      16'b1_000_0_0_0000_1_0_1001,   // R9 reset clears dq5
      16'b1_101_0_0_0100_0_0_1010,   // R10 erase window busy
      16'b1_000_0_0_0000_1_0_0101,   // R5 reset during erase window
      16'b0_000_0_0_0000_1_0_0001    // R1 idle stays read
   };

   task automatic cyc(input logic v, input logic [2:0] c, input logic d, input logic f);
      cmd_vld = v; cmd = c; eng_done = d; eng_fail = f;
      @(posedge clk);
      @(negedge clk);
      cmd_vld = 1'b0; eng_done = 1'b0; eng_fail = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, K_RST, 1'b0, 1'b0);
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic erase_go();
      cyc(1'b1, K_ESU, 1'b0, 1'b0);
      idle(WIN_W);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 20000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      int cnt;
      int bad;
      repeat (3) @(negedge clk);
      chk("R1", {mode, rdy, dq5}, {S_READ, 1'b1, 1'b0});
      rst_n = 1'b1;
      idle(4);
      chk("R1", {mode, rdy, dq5}, {S_READ, 1'b1, 1'b0});

      for (int i = 0; i < NV; i++) begin
         cyc(VEC[i][15], VEC[i][14:12], VEC[i][11], VEC[i][10]);
         chk($sformatf("R%0d row %0d", VEC[i][3:0], i), {mode, rdy, dq5}, VEC[i][9:4]);
      end

      // R11 erase window length and restart
      cyc(1'b1, K_ESU, 1'b0, 1'b0);
      cnt = (mode == S_EWIN) ? 1 : 0;
      for (int i = 0; i < 20 && mode == S_EWIN; i++) begin
         idle(1);
         if (mode == S_EWIN) cnt++;
      end
      chk("R11 window", 8'(cnt), 8'(WIN_W));
      chk("R11 erase", {mode, rdy, dq5}, {S_ERASE, 1'b0, 1'b0});
      cyc(1'b0, K_RST, 1'b1, 1'b0);
      chk("R11 erase done", 8'(mode), 8'(S_READ));
      cyc(1'b1, K_ESU, 1'b0, 1'b0);
      cnt = 1;
      idle(2); cnt += 2;
      cyc(1'b1, K_ESU, 1'b0, 1'b0); cnt++;
      for (int i = 0; i < 20 && mode == S_EWIN; i++) begin
         idle(1);
         if (mode == S_EWIN) cnt++;
      end
      chk("R11 restart", 8'(cnt), 8'(3 + WIN_W));

      // R12 suspend, suspended program, resume
      cyc(1'b1, K_SUS, 1'b0, 1'b0);
      chk("R12 suspend", {mode, rdy, dq5}, {S_ESUSP, 1'b1, 1'b0});
      cyc(1'b1, K_RST, 1'b0, 1'b0);
      chk("R12 reset ignored", 8'(mode), 8'(S_ESUSP));
      cyc(1'b1, K_PRG, 1'b0, 1'b0);
      chk("R12 susp program", {mode, rdy, dq5}, {S_SPROG, 1'b0, 1'b0});
      cyc(1'b1, K_RST, 1'b0, 1'b0);
      chk("R7 susp program", 8'(mode), 8'(S_SPROG));
      cyc(1'b0, K_RST, 1'b1, 1'b0);
      chk("R12 back to suspend", 8'(mode), 8'(S_ESUSP));
      cyc(1'b1, K_RES, 1'b0, 1'b0);
      chk("R12 resume", 8'(mode), 8'(S_ERASE));
      cyc(1'b0, K_RST, 1'b0, 1'b1);
      chk("R8 erase fail", {mode, rdy, dq5}, {S_EFAIL, 1'b1, 1'b1});
      cyc(1'b1, K_RST, 1'b0, 1'b0);
      chk("R9 clear", {mode, dq5}, {S_READ, 1'b0});
      erase_go();
      cyc(1'b1, K_SUS, 1'b0, 1'b0);
      cyc(1'b1, K_UNL, 1'b0, 1'b0);
      chk("R12 susp partial", 8'(mode), 8'(S_SPART));
      cyc(1'b1, K_RST, 1'b0, 1'b0);
      chk("R5 susp partial", 8'(mode), 8'(S_READ));
      erase_go();
      cyc(1'b1, K_SUS, 1'b0, 1'b0);
      cyc(1'b1, K_PRG, 1'b0, 1'b0);
      cyc(1'b0, K_RST, 1'b0, 1'b1);
      chk("R8 susp prog fail", {mode, dq5}, {S_PFAIL, 1'b1});
      cyc(1'b1, K_RST, 1'b0, 1'b0);

      // R13 command during a short low pulse
      pin_n = 1'b0; idle(3); pin_n = 1'b1;
      cyc(1'b1, K_PARQ, 1'b0, 1'b0);
      chk("R13 cmd ignored", 8'(mode), 8'(S_READ));
      idle(4);

      // R3 short pulses
      cyc(1'b1, K_IDQ, 1'b0, 1'b0);
      pin_n = 1'b0; idle(MIN_W - 1); pin_n = 1'b1; idle(4);
      chk("R3 query kept", 8'(mode), 8'(S_IDQ));
      // R2 full pulse from a query mode
      pin_n = 1'b0; idle(MIN_W); pin_n = 1'b1; idle(4);
      chk("R2 query to read", 8'(mode), 8'(S_READ));
      cyc(1'b1, K_PRG, 1'b0, 1'b0);
      pin_n = 1'b0; idle(MIN_W - 1); pin_n = 1'b1; idle(4);
      chk("R3 program kept", 8'(mode), 8'(S_PROG));
      cyc(1'b0, K_RST, 1'b0, 1'b1);
      pin_n = 1'b0; idle(MIN_W); pin_n = 1'b1; idle(4);
      chk("R2 fail to read", {mode, dq5}, {S_READ, 1'b0});

      // R4 recovery from program and from erase
      for (int k = 0; k < 2; k++) begin
         if (k == 0) cyc(1'b1, K_PRG, 1'b0, 1'b0);
         else        erase_go();
         cnt = 0; bad = 0;
         pin_n = 1'b0;
         for (int i = 0; i < 40; i++) begin
            if (i == MIN_W) pin_n = 1'b1;
            idle(1);
            if (mode == S_HWREC) begin
               cnt++;
               if (rdy !== 1'b0) bad++;
            end
         end
         chk("R4 recover length", 8'(cnt), 8'(REC_W));
         chk("R10 recover busy", 8'(bad), 8'd0);
         chk("R4 end in read", {mode, rdy}, {S_READ, 1'b1});
      end

      summary();
   end
endmodule